// File: doc/BRIEF.md
# Serial-Clock Hold Detector for Converter Sync and Power-Down

This controller sits beside a delta-sigma converter's digital back end. It watches the level of the serial clock line after that line has been synchronized into the system-clock domain. It counts how many conversion cycles the line stays high without a break. Each conversion cycle reaches the block as a one-clock tick.

When the line has stayed high for a short run of conversion cycles, the converter is placed in a synchronization hold. In this hold the modulator and filter are kept in reset, and the ready pin gives one low pulse and is then forced high. If the line stays high for a much longer run, the block goes on into power-down. It then also switches off the conversion-tick generator.

The first low sample of the serial clock releases either state. A restart wait of fixed length then follows. At its end the block marks the first ready pulse, which carries valid data. Several converters that share one serial clock line therefore restart together on the same falling edge.

Top module: `sclk_hold_ctrl`

## Requirements
- R1: After a synchronous reset the block is running: mod_reset, pwr_down, rdy_low, rdy_high and first_rdy are 0, and tick_en is 1.
- R2: A high level on sclk_sync that ends before HOLD_CYC ticks (default 4) have been counted has no effect. Any low sample clears the tick count.
- R3: At the clock edge that samples the HOLD_CYC-th tick with sclk_sync still high, mod_reset rises. rdy_low is 1 for exactly the one clock that follows this edge.
- R4: rdy_high is 1 in the hold, in power-down, and for the whole restart wait.
- R5: At the edge that samples the PD_CYC-th tick of one unbroken high level (default 20), pwr_down rises and tick_en falls.
- R6: In the hold, the first low sample of sclk_sync clears mod_reset at the next edge. first_rdy then pulses for one clock, SYNC_WAIT clocks (default 1537) after that edge.
- R7: In power-down, the first low sample clears mod_reset and pwr_down and sets tick_en. first_rdy then pulses PD_WAIT clocks (default 2043) after that edge.
- R8: A new hold during a restart wait cancels the wait. No first_rdy appears until the next release and its full wait have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_tick | input | 1 | One-clock pulse once per conversion cycle |
| sclk_sync | input | 1 | Serial clock level, already synchronized to clk |
| mod_reset | output | 1 | Holds the modulator and filter in reset |
| pwr_down | output | 1 | Power-down state |
| tick_en | output | 1 | Enable for the conversion-tick generator |
| rdy_low | output | 1 | Forces the ready pin low (single pulse on hold entry) |
| rdy_high | output | 1 | Forces the ready pin high |
| first_rdy | output | 1 | Marks the first valid ready after a restart |

## Verification
The detector is driven with several serial clock patterns, and a behavioural model checks every output on every clock:
- Two high levels, each a little shorter than the hold threshold and split by a low gap. This shows whether the tick count really clears on a low sample.
- A five-cycle hold followed by release. This isolates the sync restart wait.
- A hold longer than twenty cycles, which separates the power-down path and its longer wait from the sync path.
- A second hold placed inside a running restart wait. This shows whether the pending first-ready marker is cancelled.

// File: rtl/sclk_hold_ctrl.sv
module sclk_hold_ctrl #(
  parameter int HOLD_CYC  = 4,
  parameter int PD_CYC    = 20,
  parameter int SYNC_WAIT = 1537,
  parameter int PD_WAIT   = 2043
) (
  input  logic clk,
  input  logic rst,
  input  logic cyc_tick,
  input  logic sclk_sync,
  output logic mod_reset,
  output logic pwr_down,
  output logic tick_en,
  output logic rdy_low,
  output logic rdy_high,
  output logic first_rdy
);
  localparam int HW = $clog2(PD_CYC + 1);
  localparam int WMAX = (SYNC_WAIT > PD_WAIT) ? SYNC_WAIT : PD_WAIT;
  localparam int WW = $clog2(WMAX + 1);

  typedef enum logic [1:0] {RUN, HOLD_RESET, POWER_DOWN} mode_t;

  mode_t         mode;
  logic [HW-1:0] hcnt;
  logic [WW-1:0] wcnt;
  logic          go_hold;

  assign go_hold   = (mode == RUN) && sclk_sync && cyc_tick && (hcnt == HW'(HOLD_CYC - 1));
  assign mod_reset = (mode != RUN);
  assign pwr_down  = (mode == POWER_DOWN);
  assign tick_en   = (mode != POWER_DOWN);
  assign rdy_high  = (mode != RUN) || (wcnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= RUN;
      hcnt      <= '0;
      wcnt      <= '0;
      rdy_low   <= 1'b0;
      first_rdy <= 1'b0;
    end else begin
      rdy_low   <= go_hold;
      first_rdy <= (mode == RUN) && (wcnt == WW'(1)) && !go_hold;
      if (!sclk_sync)
        hcnt <= '0;
      else if (cyc_tick && mode != POWER_DOWN && hcnt != HW'(PD_CYC))
        hcnt <= hcnt + 1'b1;
      case (mode)
        RUN: begin
          if (go_hold) begin
            mode <= HOLD_RESET;
            wcnt <= '0;
          end else if (wcnt != '0) begin
            wcnt <= wcnt - 1'b1;
          end
        end
        HOLD_RESET: begin
          if (!sclk_sync) begin
            mode <= RUN;
            wcnt <= WW'(SYNC_WAIT);
          end else if (cyc_tick && hcnt == HW'(PD_CYC - 1)) begin
            mode <= POWER_DOWN;
          end
        end
        default: begin
          if (!sclk_sync) begin
            mode <= RUN;
            wcnt <= WW'(PD_WAIT);
          end
        end
      endcase
    end
  end

  // R2
  low_no_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mod_reset && !sclk_sync) |=> !mod_reset);
  // R3
  low_pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
    rdy_low |=> !rdy_low);
  // R5
  pd_from_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_down) |-> $past(mod_reset));
  // R6
  release_on_low_chk: assert property (@(posedge clk) disable iff (rst)
    (mod_reset && !sclk_sync) |=> !mod_reset);
  // R4
  first_after_wait_chk: assert property (@(posedge clk) disable iff (rst)
    first_rdy |-> (!mod_reset && $past(rdy_high)));
endmodule

// File: tb/sclk_hold_ctrl_test.sv
module sclk_hold_ctrl_test;
  localparam int PER = 16;
  logic clk = 1'b0, rst = 1'b1, cyc_tick = 1'b0, sclk_sync = 1'b0;
  logic mod_reset, pwr_down, tick_en, rdy_low, rdy_high, first_rdy;
  int checks = 0, errors = 0, tcnt = 0;
  int m_st = 0, m_h = 0, m_w = 0, m_lp = 0, m_fr = 0;

  always #2.5 clk = ~clk;

  sclk_hold_ctrl uut (.clk(clk), .rst(rst), .cyc_tick(cyc_tick), .sclk_sync(sclk_sync),
    .mod_reset(mod_reset), .pwr_down(pwr_down), .tick_en(tick_en),
    .rdy_low(rdy_low), .rdy_high(rdy_high), .first_rdy(first_rdy));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    tcnt++;
    cyc_tick <= (tcnt % PER == 0) && tick_en;
  end

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_h = 0; m_w = 0; m_lp = 0; m_fr = 0;
    end else begin
      automatic int s = sclk_sync, t = cyc_tick, old = m_st, hold;
      hold = (m_st == 0) && s && t && (m_h == 3);
      m_lp = hold;
      m_fr = (m_st == 0) && (m_w == 1) && !hold;
      if (old == 0) begin
        if (hold) begin m_st = 1; m_w = 0; end
        else if (m_w > 0) m_w--;
      end else if (old == 1) begin
        if (!s) begin m_st = 0; m_w = 1537; end
        else if (t && m_h == 19) m_st = 2;
      end else if (!s) begin
        m_st = 0; m_w = 2043;
      end
      if (!s) m_h = 0;
      else if (t && old != 2 && m_h < 20) m_h++;
    end
  end

  always @(negedge clk) if (!rst) begin
    chk("R3 mod_reset", mod_reset, m_st != 0);
    chk("R3 rdy_low", rdy_low, m_lp);
    chk("R5 pwr_down", pwr_down, m_st == 2);
    chk("R5 tick_en", tick_en, m_st != 2);
    chk("R4 rdy_high", rdy_high, (m_st != 0) || (m_w != 0));
    chk("R6 first_rdy", first_rdy, m_fr);
  end

  task automatic hi(input int n);
    sclk_sync = 1'b1; repeat (n) @(negedge clk);
  endtask
  task automatic lo(input int n);
    sclk_sync = 1'b0; repeat (n) @(negedge clk);
  endtask
  task automatic measure(input string req, input int exp);
    int k = 0;
    sclk_sync = 1'b0;
    do begin @(negedge clk); k++; end while (!first_rdy && k < 5000);
    chk(req, k, exp);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 mod_reset", mod_reset, 0);
        chk("R1 pwr_down", pwr_down, 0);
        chk("R1 tick_en", tick_en, 1);
        chk("R1 rdy_high", rdy_high, 0);
        chk("R1 rdy_low", rdy_low, 0);
        chk("R1 first_rdy", first_rdy, 0);
        hi(3 * PER + 4); lo(3); hi(3 * PER + 4); lo(20);
        chk("R2 short highs", mod_reset, 0);
        hi(5 * PER + 2);
        chk("R3 hold entered", mod_reset, 1);
        chk("R4 forced high", rdy_high, 1);
        measure("R6 sync wait", 1537 + 1);
        lo(30);
        hi(22 * PER);
        chk("R5 power-down", pwr_down, 1);
        chk("R5 tick gated", tick_en, 0);
        measure("R7 power-down wait", 2043 + 1);
        chk("R7 tick back", tick_en, 1);
        lo(30);
        hi(5 * PER); lo(500);
        chk("R8 high in wait", rdy_high, 1);
        hi(5 * PER);
        chk("R8 re-hold", mod_reset, 1);
        chk("R8 no first", first_rdy, 0);
        measure("R8 fresh wait", 1537 + 1);
        lo(20);
      end
      begin
        repeat (50000) @(negedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule